// File: doc/BRIEF.md
# Revolution-Count Motor Positioner

This block positions a brushed dc motor in whole shaft revolutions. The motor turns an encoder that gives one index pulse per revolution. The block keeps a signed position count that starts at a home value in the middle of the range. When the move button is pressed, it takes an 8-bit target sampled from a potentiometer ADC. It then enables the forward or reverse leg of an H-bridge until the count reaches the target.

Mechanical inertia carries the shaft past the stopping point. To deal with this, the block leaves the drive off for a programmable number of clock cycles after each stop, and index pulses keep being counted during that time. It then compares the count with the target again and drives back by the overrun. A parameter limits the number of such correction passes. If the motor is still off target once that limit is used up, the block stops and raises a hunting flag instead of oscillating for ever. Speed control, profiling and the bridge itself sit outside the block.

Top module: `rev_positioner`

## Requirements
- R1: During and right after reset, `pos_o` is 127 and `fwd_o`, `rev_o`, `busy_o`, `done_o` and `hunt_o` are all 0.
- R2: `target_i` is latched only on a rising edge of `move_i` seen while `busy_o` is 0. Changes of `target_i` and further `move_i` edges while busy, or `target_i` changes with no press, do not affect motion or position.
- R3: After a press, `fwd_o` is driven if the latched target is above `pos_o` and `rev_o` if it is below. If they are equal, the move ends with `done_o` and no drive at all.
- R4: `pos_o` is a 10-bit two's complement count. Each rising edge of `index_i`, after a two-flop synchroniser, changes it by exactly one, however long the pulse lasts: +1 if the latched direction is forward, -1 if reverse. This happens in every state, idle and settling included. The latched direction is forward after reset.
- R5: The drive is switched off in the cycle after `pos_o` reaches the latched target.
- R6: After each stop, the drive stays off for at least `settle_cycles_i` cycles. The count is then compared again, and any overrun is driven back in the opposite direction.
- R7: `fwd_o` and `rev_o` are never both 1, and one never follows the other without at least one cycle with both at 0.
- R8: At most MAX_CORR (default 2) correction passes follow the first run. If the position is still off target after the last one, `hunt_o` is set, `done_o` stays 0, `busy_o` drops and the drive stays off.
- R9: `busy_o` is 1 from the press until the move ends. `done_o` is set on success and held until the next accepted press, which clears both `done_o` and `hunt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| target_i | input | 8 | Target position from the ADC sample |
| move_i | input | 1 | Move pushbutton, asynchronous |
| index_i | input | 1 | Once-per-revolution index pulse, asynchronous |
| settle_cycles_i | input | 16 | Settle wait after each stop, in clock cycles |
| fwd_o | output | 1 | Forward bridge enable |
| rev_o | output | 1 | Reverse bridge enable |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | Last move reached its target |
| hunt_o | output | 1 | Last move ran out of correction passes |
| pos_o | output | 10 | Current position, two's complement |

## Verification
The hardest condition to reach from the ports is the correction-limit exit. It needs an overshoot after every stop, with the index pulses of each overshoot arriving inside the settle window. The bench contains a motor model that emits index pulses at a fixed spacing while driven. After each stop it emits a programmable number of coast pulses, in the direction of the last drive, either after the first stop only or after every stop. A target 5 revolutions away with 2 coast pulses after every stop swings between 7 and 3 until the pass limit is used up, which makes the hunting exit happen on a known pass.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_RUN    = 2'd2,
    ST_SETTLE = 2'd3
  } st_e;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;
endpackage

// File: rtl/rp_edge_sync.sv
module rp_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], async_i[g]};
    end
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R4: one count per pulse, never two adjacent strobes
    p_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/rp_pos_counter.sv
module rp_pos_counter import rp_pkg::*; #(
  parameter int POS_W = 10,
  parameter int TGT_W = 8,
  parameter int HOME  = 127
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  dir_e                    dir_i,
  input  logic [TGT_W-1:0]        tgt_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic                    above_o,
  output logic                    below_o
);
  localparam int EXT_W = POS_W - TGT_W;
  localparam logic signed [POS_W-1:0] HOME_V = POS_W'(HOME);

  logic signed [POS_W-1:0] pos_q;
  logic signed [POS_W-1:0] tgt_s;

  assign tgt_s = $signed({{EXT_W{1'b0}}, tgt_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pos_q <= HOME_V;
    else if (step_i && dir_i == DIR_FWD) pos_q <= pos_q + POS_W'(1);
    else if (step_i)                pos_q <= pos_q - POS_W'(1);
  end

  assign pos_o   = pos_q;
  assign above_o = pos_q > tgt_s;
  assign below_o = pos_q < tgt_s;

  p_step_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_FWD) |=> pos_q == $past(pos_q) + POS_W'(1));
  p_step_rev_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_REV) |=> pos_q == $past(pos_q) - POS_W'(1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/rp_settle_timer.sv
module rp_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R6: after a load, expiry is not seen before the wait has run
  p_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !expired_o);
endmodule

// File: rtl/rp_seq.sv
module rp_seq import rp_pkg::*; #(
  parameter int TGT_W    = 8,
  parameter int MAX_CORR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             move_rise_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic             above_i,
  input  logic             below_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [TGT_W-1:0] tgt_o,
  output dir_e             dir_o,
  output logic             fwd_o,
  output logic             rev_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             hunt_o
);
  localparam int CORR_W = $clog2(MAX_CORR + 2);
  localparam logic [CORR_W-1:0] CORR_MAX = CORR_W'(MAX_CORR);

  st_e              state_q;
  dir_e             dir_q;
  logic [TGT_W-1:0] tgt_q;
  logic [CORR_W-1:0] corr_q;
  logic             done_q, hunt_q;
  logic             at_tgt, stop_hit;

  assign at_tgt   = !above_i && !below_i;
  // stop on reaching or passing the target in the running direction
  assign stop_hit = (dir_q == DIR_FWD) ? !below_i : !above_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_FWD;
      tgt_q   <= '0;
      corr_q  <= '0;
      done_q  <= 1'b0;
      hunt_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (move_rise_i) begin
          tgt_q   <= target_i;
          corr_q  <= '0;
          done_q  <= 1'b0;
          hunt_q  <= 1'b0;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (at_tgt) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (corr_q > CORR_MAX) begin
            hunt_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            dir_q   <= above_i ? DIR_REV : DIR_FWD;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (stop_hit) state_q <= ST_SETTLE;
        ST_SETTLE: if (tmr_expired_i) begin
          corr_q  <= corr_q + CORR_W'(1);
          state_q <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tmr_load_o = (state_q == ST_RUN) && stop_hit;
  assign tgt_o      = tgt_q;
  assign dir_o      = dir_q;
  assign fwd_o      = (state_q == ST_RUN) && (dir_q == DIR_FWD);
  assign rev_o      = (state_q == ST_RUN) && (dir_q == DIR_REV);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign hunt_o     = hunt_q;

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_o && rev_o));
  p_dead_fr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |=> !rev_o);
  p_dead_rf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_o |=> !fwd_o);
  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && at_tgt) |=> !fwd_o && !rev_o);
  p_settle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !tmr_expired_i) |=> state_q == ST_SETTLE);
  p_hunt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hunt_o) |-> corr_q > CORR_MAX);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !fwd_o && !rev_o);
  p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && hunt_o));
  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(tgt_q)));
endmodule

// File: rtl/rev_positioner.sv
module rev_positioner import rp_pkg::*; #(
  parameter int TGT_W       = 8,
  parameter int POS_W       = 10,
  parameter int HOME        = 127,
  parameter int SETTLE_W    = 16,
  parameter int MAX_CORR    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TGT_W-1:0]    target_i,
  input  logic                move_i,
  input  logic                index_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic                fwd_o,
  output logic                rev_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                hunt_o,
  output logic [POS_W-1:0]    pos_o
);
  localparam int IDX_MOVE  = 0;
  localparam int IDX_INDEX = 1;

  logic [1:0]              rise;
  logic                    above, below, tmr_load, tmr_expired;
  logic [TGT_W-1:0]        tgt;
  dir_e                    dir;
  logic signed [POS_W-1:0] pos;

  rp_edge_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({index_i, move_i}),
    .rise_o  (rise)
  );

  rp_pos_counter #(.POS_W(POS_W), .TGT_W(TGT_W), .HOME(HOME)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (rise[IDX_INDEX]),
    .dir_i   (dir),
    .tgt_i   (tgt),
    .pos_o   (pos),
    .above_o (above),
    .below_o (below)
  );

  rp_settle_timer #(.CNT_W(SETTLE_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (settle_cycles_i),
    .expired_o (tmr_expired)
  );

  rp_seq #(.TGT_W(TGT_W), .MAX_CORR(MAX_CORR)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .move_rise_i   (rise[IDX_MOVE]),
    .target_i      (target_i),
    .above_i       (above),
    .below_i       (below),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tgt_o         (tgt),
    .dir_o         (dir),
    .fwd_o         (fwd_o),
    .rev_o         (rev_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .hunt_o        (hunt_o)
  );

  assign pos_o = pos;
endmodule

// File: tb/rev_positioner_bench.sv
module rev_positioner_bench;
  localparam int PER = 10;
  localparam int PW = 3;
  localparam int SETTLE = 60;
  localparam int NV = 8;
  // [31:24] target [23:20] coast [19] coast every stop [18] exp done [17] exp hunt [9:0] exp pos
  localparam logic [31:0] VEC [NV] = '{
    {8'd140, 4'd0, 1'b0, 1'b1, 1'b0, 7'd0, 10'd140},
    {8'd100, 4'd0, 1'b0, 1'b1, 1'b0, 7'd0, 10'd100},
    {8'd110, 4'd1, 1'b0, 1'b1, 1'b0, 7'd0, 10'd110},
    {8'd255, 4'd0, 1'b0, 1'b1, 1'b0, 7'd0, 10'd255},
    {8'd0,   4'd3, 1'b0, 1'b1, 1'b0, 7'd0, 10'd0},
    {8'd0,   4'd0, 1'b0, 1'b1, 1'b0, 7'd0, 10'd0},
    {8'd5,   4'd2, 1'b1, 1'b0, 1'b1, 7'd0, 10'd7},
    {8'd200, 4'd0, 1'b0, 1'b1, 1'b0, 7'd0, 10'd200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] target;
  logic move, mot_idx, man_idx;
  logic [15:0] settle;
  logic fwd, rev, busy, done, hunt;
  logic [9:0] pos;

  always #10 clk = ~clk;

  rev_positioner u_rev_positioner (
    .clk_i(clk), .rst_ni(rst_n), .target_i(target), .move_i(move),
    .index_i(mot_idx | man_idx), .settle_cycles_i(settle),
    .fwd_o(fwd), .rev_o(rev), .busy_o(busy), .done_o(done),
    .hunt_o(hunt), .pos_o(pos)
  );

  int checks = 0, errors = 0;
  int coast_n = 0;
  bit coast_all = 1'b0;

  // motor model and monitors
  int ph, pw_left, coast_left, phys, mdir, drive_cycles, first_dir, gap;
  int overlap_ev, gap_bad, gap_seen;
  bit drive_prev, coast_used, after_stop, fwd_p, rev_p, move_p, busy_seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0; pw_left = 0; coast_left = 0; phys = 127; mdir = 1;
      drive_prev = 0; coast_used = 0; after_stop = 0; fwd_p = 0; rev_p = 0;
      mot_idx = 1'b0; gap = 0;
    end else begin
      if (move && !move_p) begin
        coast_used = 0; first_dir = 0; drive_cycles = 0; busy_seen = 0;
      end
      if (busy) busy_seen = 1;
      if (fwd && rev) overlap_ev++;
      if ((fwd_p && rev) || (rev_p && fwd)) overlap_ev++;
      if (pw_left > 0) begin
        pw_left--;
        if (pw_left == 0) mot_idx = 1'b0;
      end
      if (fwd || rev) begin
        if (!drive_prev) begin
          ph = 0;
          if (after_stop) begin
            gap_seen++;
            if (gap < SETTLE) gap_bad++;
          end
          if (first_dir == 0) first_dir = fwd ? 1 : 2;
        end
        after_stop = 0;
        mdir = fwd ? 1 : -1;
        drive_cycles++;
        ph++;
        if (ph == PER) begin
          ph = 0; mot_idx = 1'b1; pw_left = PW; phys += mdir;
        end
      end else begin
        if (drive_prev) begin
          after_stop = 1; gap = 0; ph = 0;
          if (coast_all || !coast_used) coast_left = coast_n;
          coast_used = 1;
        end
        if (busy && after_stop) gap++;
        if (coast_left > 0) begin
          ph++;
          if (ph == PER) begin
            ph = 0; mot_idx = 1'b1; pw_left = PW; phys += mdir; coast_left--;
          end
        end
      end
      if (!busy) after_stop = 0;
      drive_prev = fwd || rev; fwd_p = fwd; rev_p = rev;
    end
    move_p = move;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input logic [7:0] t);
    target = t;
    @(negedge clk);
    move = 1'b1;
    repeat (4) @(negedge clk);
    move = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (!(busy_seen && !busy) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    target = 8'd127; move = 1'b0; man_idx = 1'b0; settle = 16'(SETTLE);
    overlap_ev = 0; gap_bad = 0; gap_seen = 0; busy_seen = 0;
    first_dir = 0; drive_cycles = 0; move_p = 0;
    repeat (3) @(negedge clk);
    chk(pos == 10'd127 && !fwd && !rev && !busy && !done && !hunt,
        "R1 reset state", int'(pos), 127);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pos == 10'd127 && !busy && !done, "R1 after release", int'(pos), 127);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      int start;
      v = VEC[i];
      start = $signed(pos);
      coast_n = int'(v[23:20]);
      coast_all = v[19];
      press(v[31:24]);
      wait_end();
      chk(pos == v[9:0], v[17] ? "R8 hunt end position" : "R6 final position",
          $signed(pos), $signed(v[9:0]));
      chk(phys == $signed(pos), "R4 count matches revolutions", $signed(pos), phys);
      chk(done == v[18], "R9 done flag", int'(done), int'(v[18]));
      chk(hunt == v[17] && !busy && !fwd && !rev, "R8 hunt flag", int'(hunt), int'(v[17]));
      if (start == int'(v[31:24]))
        chk(drive_cycles == 0, "R3 no drive when on target", drive_cycles, 0);
      else
        chk(first_dir == ((int'(v[31:24]) > start) ? 1 : 2), "R3 first direction",
            first_dir, (int'(v[31:24]) > start) ? 1 : 2);
    end

    // R2: target change and extra press while busy are ignored
    coast_n = 0; coast_all = 0;
    press(8'd90);
    repeat (10) @(negedge clk);
    target = 8'd10;
    move = 1'b1;
    repeat (4) @(negedge clk);
    move = 1'b0;
    wait_end();
    chk(pos == 10'd90 && done, "R2 latched target kept", int'(pos), 90);

    // R2: target change with no press
    begin
      int dc;
      dc = drive_cycles;
      target = 8'd10;
      repeat (100) @(negedge clk);
      chk(drive_cycles == dc && pos == 10'd90 && done, "R2 no press no motion",
          drive_cycles - dc, 0);
    end

    // R4: a wide index pulse while idle counts once in latched (reverse) direction
    man_idx = 1'b1;
    repeat (8) @(negedge clk);
    man_idx = 1'b0;
    repeat (5) @(negedge clk);
    chk(pos == 10'd89, "R4 idle pulse counted once", int'(pos), 89);

    // R9: done cleared by an accepted press, busy during move
    press(8'd95);
    repeat (5) @(negedge clk);
    chk(busy && !done, "R9 busy and done cleared", int'(done), 0);
    wait_end();
    chk(pos == 10'd95 && done, "R5 short forward move", int'(pos), 95);

    // R5: drive drops one cycle after the count meets the target
    begin
      int t = 0;
      press(8'd97);
      while (pos != 10'd97 && t < 2000) begin @(negedge clk); t++; end
      chk(fwd, "R5 drive still on in cycle of match", int'(fwd), 1);
      @(negedge clk);
      chk(!fwd && !rev, "R5 drive off after match", int'(fwd), 0);
      wait_end();
    end

    // R1: reset in the middle of a move
    press(8'd150);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!fwd && !rev && !busy && pos == 10'd127, "R1 reset mid-move", int'(pos), 127);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(overlap_ev == 0, "R7 overlap or direct reversal events", overlap_ev, 0);
    chk(gap_seen > 0 && gap_bad == 0, "R6 settle gap before correction", gap_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule